// File: doc/BRIEF.md
# Partitioned SIMD Adder/Subtractor

A combinational 16-bit arithmetic unit. A mask chosen at run time splits its datapath into independent lanes. The datapath is built from four 4-bit chunks. Each of the three internal chunk seams can be opened by one bit of the partition mask. When a seam is open, no carry passes across it. One adder therefore serves as a single 16-bit lane, as two 8-bit lanes, as four 4-bit lanes, or as any mixed layout such as 4+12 or 8+4+4.

Every lane performs the same operation: add, subtract or negate. The carry-in vector has one bit per chunk, and a lane takes its carry-in from the bit of its lowest chunk. The 4-bit carry-out vector reports each lane's overflow at the index of that lane's lowest chunk.

The unit is used in SIMD integer datapaths, where the same hardware must handle packed short elements and full-width words without duplicating adders.

Top module: `simd_addsub`

## Requirements
- R1: With a partition mask of 0 and the add operation, result equals (a + b + carry_in[0]) mod 2^16, and carry_out[0] is the bit-16 carry of that sum.
- R2: Mask bit i (i = 0..2) opens the seam at bit position 4*(i+1), so 3'b010 gives two 8-bit lanes and 3'b111 gives four 4-bit lanes. No carry crosses an open seam, and each lane's result depends only on that lane's operand bits.
- R3: Each lane takes its carry-in from carry_in[j], where j is the index of the lane's lowest chunk. The carry_in bits of the lane's other chunks have no effect on result or carry_out.
- R4: Subtract (op_sel = 2'b01) computes, per lane, a + ~b + carry-in, so a carry-in of 1 gives a - b in two's complement.
- R5: Negate (op_sel = 2'b10) returns, per lane, the two's complement of a (that is, ~a + 1) and ignores carry_in and b. The lane carry-out is 1 exactly when the lane's bits of a are all zero.
- R6: A lane's carry-out is the carry out of the lane's top bit. It appears at carry_out index (lane LSB position / 4).
- R7: Every carry_out bit whose chunk is not the lowest chunk of a lane is 0.
- R8: op_sel encodings: 2'b00 add, 2'b01 subtract, 2'b10 negate, 2'b11 behaves as add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 negate, 3 add |
| part_mask | input | 3 | Bit i opens the seam at bit 4*(i+1) |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| carry_in | input | 4 | Per-chunk carry-in; a lane uses the bit of its lowest chunk |
| result | output | 16 | Per-lane result |
| carry_out | output | 4 | Per-lane carry-out at the lane's lowest chunk index |

## Verification
The bench builds the unit with its default 4-bit chunks and four chunks. At that size a full sweep is affordable: every one of the 8 partition masks, all 16 carry-in vectors and all 4 operation codes, each applied to a set of corner and pseudo-random operand pairs. Every combination is compared against a lane-by-lane integer model computed in the bench. Because the sweep covers all mask values, it exercises mixed layouts such as 12+4 and 4+8+4, and it shows that ignored carry-in bits change nothing.

// File: rtl/simd_addsub_pkg.sv
// Shared operation codes for the partitioned add/subtract unit.
package simd_addsub_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_NEG  = 2'b10,
        OP_ADD2 = 2'b11
    } addsub_op_e;
endpackage

// File: rtl/part_bounds.sv
// Decodes the seam mask into per-chunk lane-start and lane-end flags.
// Assumes chunk 0 always starts a lane and the top chunk always ends one.
module part_bounds #(
    parameter int NUM_CHUNKS = 4
) (
    input  logic [NUM_CHUNKS-2:0] seam_mask,
    output logic [NUM_CHUNKS-1:0] lane_start,
    output logic [NUM_CHUNKS-1:0] lane_end
);
    // A chunk starts a lane when the seam below it is open; it ends one when the seam above is open.
    always_comb begin
        lane_start = {seam_mask, 1'b1};
        lane_end   = {1'b1, seam_mask};
    end
endmodule

// File: rtl/chunk_adder.sv
// One chunk of the carry chain: sum of two operands plus a carry-in.
// Assumes the operands are already inverted as the operation requires.
module chunk_adder #(
    parameter int CHUNK_W = 4
) (
    input  logic [CHUNK_W-1:0] x,
    input  logic [CHUNK_W-1:0] y,
    input  logic               ci,
    output logic [CHUNK_W-1:0] s,
    output logic               co
);
    // Add with an extra bit that catches the chunk carry.
    always_comb begin
        {co, s} = {1'b0, x} + {1'b0, y} + {{CHUNK_W{1'b0}}, ci};
    end
endmodule

// File: rtl/lane_carry_gather.sv
// Moves each lane's top-chunk carry down to the lane's lowest chunk index.
// Assumes start/end flags describe contiguous lanes; other bits read zero.
module lane_carry_gather #(
    parameter int NUM_CHUNKS = 4
) (
    input  logic [NUM_CHUNKS-1:0] chunk_co,
    input  logic [NUM_CHUNKS-1:0] lane_start,
    input  logic [NUM_CHUNKS-1:0] lane_end,
    output logic [NUM_CHUNKS-1:0] lane_co
);
    // Walk from the top chunk down, holding the carry of the lane currently being visited.
    always_comb begin
        logic held;
        held    = 1'b0;
        lane_co = '0;
        for (int k = NUM_CHUNKS - 1; k >= 0; k--) begin
            if (lane_end[k]) held = chunk_co[k];
            lane_co[k] = lane_start[k] & held;
        end
    end
endmodule

// File: rtl/simd_addsub.sv
// Partitioned add/subtract/negate unit built from a chain of chunk adders.
// Open seams cut the chain and inject the lane carry-in; purely combinational.
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int CHUNK_W    = 4,
    parameter int NUM_CHUNKS = 4
) (
    input  logic [1:0]                    op_sel,
    input  logic [NUM_CHUNKS-2:0]         part_mask,
    input  logic [CHUNK_W*NUM_CHUNKS-1:0] a,
    input  logic [CHUNK_W*NUM_CHUNKS-1:0] b,
    input  logic [NUM_CHUNKS-1:0]         carry_in,
    output logic [CHUNK_W*NUM_CHUNKS-1:0] result,
    output logic [NUM_CHUNKS-1:0]         carry_out
);
    localparam int DATA_W = CHUNK_W * NUM_CHUNKS;

    logic [NUM_CHUNKS-1:0] lane_start;
    logic [NUM_CHUNKS-1:0] lane_end;
    logic [NUM_CHUNKS-1:0] chunk_co;
    logic [NUM_CHUNKS-1:0] chunk_ci;
    logic [DATA_W-1:0]     x_op;
    logic [DATA_W-1:0]     y_op;
    logic                  is_sub;
    logic                  is_neg;

    part_bounds #(.NUM_CHUNKS(NUM_CHUNKS)) u_bounds (
        .seam_mask  (part_mask),
        .lane_start (lane_start),
        .lane_end   (lane_end)
    );

    // Shape the operands: subtract inverts b, negate computes ~a + 0 + 1.
    always_comb begin
        is_sub = (op_sel == OP_SUB);
        is_neg = (op_sel == OP_NEG);
        x_op   = is_neg ? ~a : a;
        y_op   = is_neg ? '0 : (is_sub ? ~b : b);
    end

    generate
        for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chunk
            // Chain carry from below, or inject the lane carry-in at a lane start.
            if (k == 0) begin : g_first
                always_comb chunk_ci[k] = is_neg | carry_in[k];
            end else begin : g_rest
                always_comb chunk_ci[k] = lane_start[k] ? (is_neg | carry_in[k]) : chunk_co[k-1];
            end

            chunk_adder #(.CHUNK_W(CHUNK_W)) u_add (
                .x  (x_op[k*CHUNK_W +: CHUNK_W]),
                .y  (y_op[k*CHUNK_W +: CHUNK_W]),
                .ci (chunk_ci[k]),
                .s  (result[k*CHUNK_W +: CHUNK_W]),
                .co (chunk_co[k])
            );
        end
    endgenerate

    lane_carry_gather #(.NUM_CHUNKS(NUM_CHUNKS)) u_gather (
        .chunk_co   (chunk_co),
        .lane_start (lane_start),
        .lane_end   (lane_end),
        .lane_co    (lane_co_w)
    );

    logic [NUM_CHUNKS-1:0] lane_co_w;
    always_comb carry_out = lane_co_w;

    // Port-level checks of lane behaviour.
    always_comb begin
        AST_COUT_AT_LANE_BASE: assert ((carry_out & ~{part_mask, 1'b1}) == '0); // R7
        if (part_mask == '0 && op_sel == OP_ADD)
            AST_WIDE_ADD: assert ({carry_out[0], result} == ({1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, carry_in[0]})); // R1
        if (op_sel == OP_NEG && a == '0)
            AST_NEG_OF_ZERO: assert (result == '0); // R5
        if (op_sel == OP_SUB && a == b && carry_in == '1)
            AST_SUB_SELF_ZERO: assert (result == '0); // R4
        if (part_mask == '1 && op_sel == OP_ADD)
            for (int k = 0; k < NUM_CHUNKS; k++)
                AST_NARROW_LANE: assert ({carry_out[k], result[k*CHUNK_W +: CHUNK_W]} == ({1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, b[k*CHUNK_W +: CHUNK_W]} + {{CHUNK_W{1'b0}}, carry_in[k]})); // R2
    end
endmodule

// File: tb/simd_addsub_bench.sv
// Sweeps every mask, carry-in vector and op code over a set of operand pairs.
module simd_addsub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [2:0]  part_mask = '0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [3:0]  carry_in = '0;
    logic [15:0] result;
    logic [3:0]  carry_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_addsub u_simd_addsub (
        .op_sel    (op_sel),
        .part_mask (part_mask),
        .a         (a),
        .b         (b),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    // Lane-by-lane integer model: returns {carry_out, result}.
    function automatic logic [19:0] model(input int op, input int mask, input int av,
                                          input int bv, input int cv);
        int res = 0;
        int cout = 0;
        int k = 0;
        while (k < 4) begin
            int w = 1;
            int lsb = 4 * k;
            int m, x, y, ci, s;
            while (k + w < 4 && ((mask >> (k + w - 1)) & 1) == 0) w++;
            m  = (1 << (4 * w)) - 1;
            x  = (av >> lsb) & m;
            y  = (bv >> lsb) & m;
            ci = (cv >> k) & 1;
            if (op == 1)      s = x + (~y & m) + ci;
            else if (op == 2) s = (~x & m) + 1;
            else              s = x + y + ci;
            res  |= (s & m) << lsb;
            cout |= ((s >> (4 * w)) & 1) << k;
            k += w;
        end
        return {cout[3:0], res[15:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: op=%0d mask=%b a=%h b=%h cin=%b actual=%h expected=%h",
                     tag, op_sel, part_mask, a, b, carry_in, act, exp);
        end
    endtask

    initial begin
        int pa [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0F0F, 16'h1234, 16'hFFFF, 16'h0001, 16'h7FFF};
        int pb [8] = '{16'h0000, 16'h0001, 16'h8000, 16'hF0F0, 16'h1234, 16'hFFFF, 16'hFFFF, 16'h0001};
        int seed = 32'h1ACE;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 zero inputs", {carry_out, result}, 20'h0);
        for (int p = 0; p < 24; p++) begin
            int av, bv;
            if (p < 8) begin
                av = pa[p]; bv = pb[p];
            end else begin
                seed ^= seed << 13; seed ^= seed >>> 17; seed ^= seed << 5;
                av = seed & 16'hFFFF; bv = (seed >> 16) & 16'hFFFF;
            end
            for (int op = 0; op < 4; op++)
                for (int mk = 0; mk < 8; mk++)
                    for (int cv = 0; cv < 16; cv++) begin
                        logic [19:0] e;
                        string tg;
                        @(posedge clk);
                        op_sel = op[1:0]; part_mask = mk[2:0];
                        a = av[15:0]; b = bv[15:0]; carry_in = cv[3:0];
                        e = model(op, mk, av, bv, cv);
                        @(negedge clk);
                        if (op == 3)      tg = "R8 op3 as add";
                        else if (op == 1) tg = "R4 subtract";
                        else if (op == 2) tg = "R5 negate";
                        else if (mk == 0) tg = "R1 wide add";
                        else              tg = "R2 lane add";
                        check(tg, result, e[15:0]);
                        // R3: ignored carry_in bits are swept through all values here
                        check((cv != 0) ? "R6 R3 lane carry" : "R6 lane carry", carry_out, e[19:16]);
                        check("R7 non-base carry zero", carry_out & ~{part_mask, 1'b1}, 0);
                    end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule